// File: doc/BRIEF.md
# Truth-Table Logic and Add/Subtract Unit

This block is the arithmetic and logic stage of a small bus-based datapath. Two operand registers sit on the A and B input buses. Each register takes a new value on a clock edge while its own load strobe is high. It keeps that value after the bus is released, so a source can place an operand and then let the bus go.

The registered operands feed two engines. The logic engine treats the 4-bit function code as a truth table over each pair of operand bits, so all sixteen two-input functions are available. The arithmetic engine is chosen by a mode bit and either adds with a carry-in or subtracts. The selected result is registered together with negative, zero and carry flags.

The result is offered to a shared result bus only while a drive request is high. On a chip without internal tri-states this appears as a data word plus a registered output-enable. The data word is forced to zero while the enable is low.

Top module: `ttab_alu`

## Requirements
- R1: On a rising edge with `load_a` (`load_b`) high, the A (B) operand register takes `a_bus` (`b_bus`). Without its strobe, a register keeps its value whatever its bus carries.
- R2: With `arith` low, result bit i equals `func[2*a_i + b_i]`, where a_i is the A operand bit and b_i the B operand bit. So code 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR, 4'b0011 is NOT A, 4'b0101 is NOT B, 4'b0000 is all zeros and 4'b1111 is all ones.
- R3: With `arith` high and `sub` low, the result is A + B + `cin`, taken modulo 2^16.
- R4: With `arith` high and `sub` high, the result is A + ~B + 1, which is A - B. In this mode `cin` has no effect.
- R5: In arithmetic mode `func` has no effect on the result.
- R6: `cout` is the carry out of bit 15 of the add in both arithmetic modes. In logic mode it is 0.
- R7: `neg` equals bit 15 of the selected result and `zero` is 1 exactly when all result bits are 0. The flags are registered on every edge, whether or not `drive` is high.
- R8: `r_en` is `drive` delayed by one edge. `r_data` holds the registered result when `drive` was high at that edge and zero otherwise.
- R9: The result registered at an edge is computed from the operand values held before that edge. An operand loaded at the same edge shows at the output only one edge later.
- R10: While `rst` is high at a rising edge, both operand registers and all outputs go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_bus | input | 16 | A operand bus |
| b_bus | input | 16 | B operand bus |
| load_a | input | 1 | Capture strobe for the A operand register |
| load_b | input | 1 | Capture strobe for the B operand register |
| func | input | 4 | Truth-table function code for logic mode |
| arith | input | 1 | 1 selects arithmetic mode |
| sub | input | 1 | In arithmetic mode, 1 selects subtraction |
| cin | input | 1 | Carry-in for addition |
| drive | input | 1 | Request to place the result on the result bus |
| r_data | output | 16 | Registered result, zero when not enabled |
| r_en | output | 1 | Registered result-bus output enable |
| neg | output | 1 | Negative flag |
| zero | output | 1 | Zero flag |
| cout | output | 1 | Carry out of the most significant bit |

## Verification
Operand capture and result registration can fall on the same edge: a load strobe is raised in the very cycle that `drive` asks for a result. The bench provokes this by loading a new A value while driving an AND. It expects the first output to come from the old A and the output one edge later to come from the new A. Reset is also asserted while `drive` is high, and the enable must drop at that edge.

// File: rtl/ttab_alu_pkg.sv
package ttab_alu_pkg;
  localparam int unsigned FUNC_W = 4;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
  } flags_t;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'b00,
    MODE_ADD   = 2'b10,
    MODE_SUB   = 2'b11
  } mode_e;
endpackage

// File: rtl/ttab_operand_reg.sv
module ttab_operand_reg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/ttab_logic_unit.sv
module ttab_logic_unit
  import ttab_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [FUNC_W-1:0] func,
  output logic [WIDTH-1:0]  res
);
  // Each result bit looks up the truth table at index {a_i, b_i}.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] idx;
    assign idx    = {opa[i], opb[i]};
    assign res[i] = func[idx];
  end
endmodule

// File: rtl/ttab_arith_unit.sv
module ttab_arith_unit #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sub,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             carry
);
  localparam int unsigned EXT_W = WIDTH + 1;

  logic [WIDTH-1:0] b_eff;
  logic             c_eff;
  logic [EXT_W-1:0] total;

  always_comb begin
    b_eff = sub ? ~opb : opb;
    c_eff = sub ? 1'b1 : cin;
    total = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
  end

  assign sum   = total[WIDTH-1:0];
  assign carry = total[WIDTH];
endmodule

// File: rtl/ttab_alu.sv
module ttab_alu
  import ttab_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  a_bus,
  input  logic [WIDTH-1:0]  b_bus,
  input  logic              load_a,
  input  logic              load_b,
  input  logic [FUNC_W-1:0] func,
  input  logic              arith,
  input  logic              sub,
  input  logic              cin,
  input  logic              drive,
  output logic [WIDTH-1:0]  r_data,
  output logic              r_en,
  output logic              neg,
  output logic              zero,
  output logic              cout
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] opa_q, opb_q;
  logic [WIDTH-1:0] logic_res, arith_res, sel_res;
  logic             arith_c;
  mode_e            mode;
  flags_t           flags_d, flags_q;

  ttab_operand_reg #(.WIDTH(WIDTH)) u_opa (
    .clk(clk), .rst(rst), .load(load_a), .d(a_bus), .q(opa_q)
  );

  ttab_operand_reg #(.WIDTH(WIDTH)) u_opb (
    .clk(clk), .rst(rst), .load(load_b), .d(b_bus), .q(opb_q)
  );

  ttab_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .opa(opa_q), .opb(opb_q), .func(func), .res(logic_res)
  );

  ttab_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .opa(opa_q), .opb(opb_q), .sub(sub), .cin(cin),
    .sum(arith_res), .carry(arith_c)
  );

  always_comb begin
    mode = arith ? (sub ? MODE_SUB : MODE_ADD) : MODE_LOGIC;
    unique case (mode)
      MODE_ADD, MODE_SUB: begin
        sel_res       = arith_res;
        flags_d.carry = arith_c;
      end
      default: begin
        sel_res       = logic_res;
        flags_d.carry = 1'b0;
      end
    endcase
    flags_d.neg  = sel_res[MSB];
    flags_d.zero = (sel_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_data  <= '0;
      r_en    <= 1'b0;
      flags_q <= '0;
    end else begin
      r_data  <= drive ? sel_res : '0;
      r_en    <= drive;
      flags_q <= flags_d;
    end
  end

  assign neg  = flags_q.neg;
  assign zero = flags_q.zero;
  assign cout = flags_q.carry;
endmodule

// File: rtl/ttab_alu_chk.sv
module ttab_alu_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_bus,
  input logic             load_a,
  input logic             arith,
  input logic             drive,
  input logic [WIDTH-1:0] opa_q,
  input logic [WIDTH-1:0] r_data,
  input logic             r_en,
  input logic             neg,
  input logic             zero,
  input logic             cout
);
  // R1: a strobe captures the bus, no strobe holds the value
  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    load_a |=> opa_q == $past(a_bus));
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !load_a |=> $stable(opa_q));

  // R8: enable follows drive; the data word is zero while released
  a_r8_enable: assert property (@(posedge clk) disable iff (rst)
    drive |=> r_en);
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    !drive |=> (!r_en && r_data == '0));

  // R7: flags agree with the word on the bus
  a_r7_neg: assert property (@(posedge clk) disable iff (rst)
    r_en |-> neg == r_data[WIDTH-1]);
  a_r7_zero: assert property (@(posedge clk) disable iff (rst)
    r_en |-> zero == (r_data == '0));

  // R6: no carry in logic mode
  a_r6_logic_nocarry: assert property (@(posedge clk) disable iff (rst)
    !arith |=> !cout);

  // R10: reset clears outputs and operand
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!r_en && r_data == '0 && !neg && !zero && !cout && opa_q == '0));
endmodule

bind ttab_alu ttab_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .a_bus(a_bus), .load_a(load_a), .arith(arith),
  .drive(drive), .opa_q(opa_q), .r_data(r_data), .r_en(r_en),
  .neg(neg), .zero(zero), .cout(cout)
);

// File: tb/ttab_alu_tb.sv
module ttab_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_bus = '0, b_bus = '0;
  logic        load_a = 1'b0, load_b = 1'b0;
  logic [3:0]  func = '0;
  logic        arith = 1'b0, sub = 1'b0, cin = 1'b0, drive = 1'b0;
  logic [15:0] r_data;
  logic        r_en, neg, zero, cout;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ttab_alu #(.WIDTH(16)) u_dut (
    .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus),
    .load_a(load_a), .load_b(load_b), .func(func), .arith(arith),
    .sub(sub), .cin(cin), .drive(drive), .r_data(r_data), .r_en(r_en),
    .neg(neg), .zero(zero), .cout(cout)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic [3:0]  f;
    logic        ar;
    logic        sb;
    logic        ci;
    logic [15:0] res;
    logic        n;
    logic        z;
    logic        c;
  } vec_t;

  localparam int NV = 14;
  // a, b, func, arith, sub, cin, result, n, z, c
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 16'hAAAA, 4'b1000, 1'b0, 1'b0, 1'b0, 16'hAAAA, 1'b1, 1'b0, 1'b0},
    '{16'hAAAA, 16'h5555, 4'b1110, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    '{16'hF0F0, 16'h03FC, 4'b0110, 1'b0, 1'b0, 1'b0, 16'hF30C, 1'b1, 1'b0, 1'b0},
    '{16'hF0F0, 16'h03FC, 4'b0011, 1'b0, 1'b0, 1'b0, 16'h0F0F, 1'b0, 1'b0, 1'b0},
    '{16'hFFFF, 16'hFFFF, 4'b0000, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b0},
    '{16'h0000, 16'h0000, 4'b1111, 1'b0, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    '{16'h1234, 16'h03FC, 4'b0101, 1'b0, 1'b0, 1'b0, 16'hFC03, 1'b1, 1'b0, 1'b0},
    '{16'h0001, 16'h0002, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0003, 1'b0, 1'b0, 1'b0},
    '{16'hFFFF, 16'h0001, 4'b0000, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1},
    '{16'h7FFF, 16'h0000, 4'b0000, 1'b1, 1'b0, 1'b1, 16'h8000, 1'b1, 1'b0, 1'b0},
    '{16'h0005, 16'h0003, 4'b0000, 1'b1, 1'b1, 1'b0, 16'h0002, 1'b0, 1'b0, 1'b1},
    '{16'h0003, 16'h0005, 4'b0000, 1'b1, 1'b1, 1'b0, 16'hFFFE, 1'b1, 1'b0, 1'b0},
    '{16'h1234, 16'h1234, 4'b1111, 1'b1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1},
    '{16'h1000, 16'h0234, 4'b1000, 1'b1, 1'b0, 1'b0, 16'h1234, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag,
                       input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Check {r_en, r_data, neg, zero, cout} against expected values.
  task automatic check_out(input string tag, input logic en, input logic [15:0] d,
                           input logic n, input logic z, input logic c);
    logic [19:0] act, exp;
    act = {r_en, r_data, neg, zero, cout};
    exp = {en, d, n, z, c};
    check(act === exp, tag, act[18:0], exp[18:0]);
    if (act[19] !== exp[19]) begin
      checks++;
      fails++;
      $display("FAIL %s: r_en got %b expected %b", tag, act[19], exp[19]);
    end
  endtask

  // Load both operands, then release the buses to a junk value.
  task automatic load_ops(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    a_bus = a; b_bus = b; load_a = 1'b1; load_b = 1'b1;
    @(negedge clk);
    load_a = 1'b0; load_b = 1'b0; a_bus = 16'hDEAD; b_bus = 16'hBEEF;
  endtask

  task automatic run_op(input logic [3:0] f, input logic ar, input logic sb,
                        input logic ci, input logic drv);
    func = f; arith = ar; sub = sb; cin = ci; drive = drv;
    @(negedge clk);
    drive = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10: reset state of every output
    check_out("R10 reset outputs", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // R10/R1: operands cleared by reset (NOT A and NOT B give all ones)
    run_op(4'b0011, 1'b0, 1'b0, 1'b0, 1'b1);
    check_out("R10 A cleared", 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0);
    run_op(4'b0101, 1'b0, 1'b0, 1'b0, 1'b1);
    check_out("R10 B cleared", 1'b1, 16'hFFFF, 1'b1, 1'b0, 1'b0);

    // Table: R2 logic, R3 add, R4 subtract, R6 carry, R7 flags
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = VECS[i].ar ? (VECS[i].sb ? "R4 sub row" : "R3 add row") : "R2 logic row";
      load_ops(VECS[i].a, VECS[i].b);
      run_op(VECS[i].f, VECS[i].ar, VECS[i].sb, VECS[i].ci, 1'b1);
      check_out($sformatf("%s %0d (R6 R7)", tag, i), 1'b1, VECS[i].res,
                VECS[i].n, VECS[i].z, VECS[i].c);
    end

    // R8 and R7: drive low releases the bus but flags still update
    load_ops(16'hFFFF, 16'hFFFF);
    run_op(4'b1111, 1'b0, 1'b0, 1'b0, 1'b0);
    check_out("R8 released, R7 flags live", 1'b0, 16'h0000, 1'b1, 1'b0, 1'b0);

    // R1: operands hold while buses change without strobes
    load_ops(16'h00FF, 16'h0F0F);
    a_bus = 16'hFFFF; b_bus = 16'hFFFF;
    repeat (2) @(negedge clk);
    run_op(4'b1000, 1'b0, 1'b0, 1'b0, 1'b1);
    check_out("R1 hold", 1'b1, 16'h000F, 1'b0, 1'b0, 1'b0);

    // R9: load A in the same cycle as drive; old A first, new A next
    a_bus = 16'hFFFF; load_a = 1'b1; func = 4'b1000; arith = 1'b0; drive = 1'b1;
    @(negedge clk);
    check_out("R9 same-edge uses old A", 1'b1, 16'h000F, 1'b0, 1'b0, 1'b0);
    load_a = 1'b0;
    @(negedge clk);
    drive = 1'b0;
    check_out("R9 next edge uses new A", 1'b1, 16'h0F0F, 1'b0, 1'b0, 1'b0);

    // R5: func ignored in arithmetic mode (XOR would give 00FE)
    load_ops(16'h00FF, 16'h0001);
    run_op(4'b0110, 1'b1, 1'b0, 1'b0, 1'b1);
    check_out("R5 func ignored", 1'b1, 16'h0100, 1'b0, 1'b0, 1'b0);

    // R4: cin ignored while subtracting
    load_ops(16'h0005, 16'h0003);
    run_op(4'b0000, 1'b1, 1'b1, 1'b1, 1'b1);
    check_out("R4 cin ignored", 1'b1, 16'h0002, 1'b0, 1'b0, 1'b1);

    // R10: reset while drive is high
    drive = 1'b1; rst = 1'b1;
    @(negedge clk);
    check_out("R10 reset over drive", 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0);
    rst = 1'b0; drive = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule